// File: doc/BRIEF.md
# Nucleotide-Character Viterbi Decoder

This block recovers one message byte from a block of eight ASCII nucleotide characters. Each character stands for two coded bits. The block turns each character back into its bit pair and runs one step of a four-state hard-decision Viterbi trellis per accepted character. The code is rate 1/2 with constraint length 3, generators 111 and 101. The trellis is not terminated: after the eighth step the block picks the state with the best metric and emits that state's survivor as the decoded byte.

The datapath has four parts. A character mapper flags illegal characters. A branch-metric unit forms Hamming distances. Four add-compare-select cells with saturating 5-bit path metrics update the states. A register-exchange survivor store holds the paths. An upstream source presents characters with a valid strobe and may leave idle cycles between them. The decoded byte, and an error flag covering the whole block, appear together for one cycle.

Top module: `nvd_decoder`

## Requirements
- R1: Characters map to bit pairs as 'A' (0x41)=00, 'C' (0x43)=01, 'G' (0x47)=10 and 'T' (0x54)=11. The first accepted character of a block is trellis step 1. In each pair the high bit is the output of generator 111 and the low bit the output of generator 101. The encoder state starts at zero.
- R2: One trellis step is taken for each cycle with `in_valid` high. Cycles with `in_valid` low advance nothing and change no decoder state.
- R3: On the clock edge that accepts the eighth character of a block, `out_valid` is set for exactly one cycle, and it is low at all other times. `out_byte` carries the first decoded bit in bit 7 and the last in bit 0.
- R4: Each path metric is updated as the smaller of (predecessor metric + Hamming branch metric) over the two predecessors, with 5-bit saturating arithmetic. A block starts with metric 0 for state 0 and 31 for the other states. Over any step the smallest metric never decreases and rises by at most 2.
- R5: An error-free codeword of any of the 256 messages decodes to exactly that message.
- R6: When the codeword contains bit errors, re-encoding the decoded byte gives a codeword at the minimum Hamming distance from the received bits over all 256 messages.
- R7: Ties resolve toward lower indices. In add-compare-select, an equal sum keeps the lower-numbered predecessor. At the final decision, the lowest state among those with the best metric is chosen. So seven 00 pairs followed by 01, or by 10, decode to 0x00.
- R8: Any character other than the four legal codes sets `out_err` for that block's result and is decoded as pair 00. The flag starts clear for each new block.
- R9: Synchronous active-high reset clears `out_valid`, `out_byte` and `out_err` and restarts the block at step 1, discarding any partial block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character strobe; one trellis step per high cycle |
| in_char | input | 8 | ASCII nucleotide character |
| out_valid | output | 1 | One-cycle strobe marking a decoded byte |
| out_byte | output | 8 | Decoded message, first bit in bit 7 |
| out_err | output | 1 | An illegal character occurred in the block |

## Verification
The result of a block is registered on the same edge that accepts its eighth character. `out_valid`, `out_byte` and `out_err` can therefore be read on the falling edge right after that rising edge, and the bench reads them there. On every falling edge inside a block, before the eighth character and during idle gaps, the bench confirms that `out_valid` is low. It also confirms that `out_valid` is low again one cycle after the pulse. Inputs change only on falling edges, so each character is consumed by exactly one known rising edge. This holds for blocks sent back to back, blocks with idle gaps, and a block cut short by reset.

// File: rtl/nvd_pkg.sv
package nvd_pkg;

    localparam int NUM_STATES = 4;

    typedef logic [1:0] pair_t;

    typedef struct packed {
        pair_t pair;
        logic  bad;
    } nuc_t;

    function automatic pair_t expected_pair(input logic [1:0] prev, input logic u);
        pair_t p;
        p[1] = u ^ prev[1] ^ prev[0];
        p[0] = u ^ prev[0];
        return p;
    endfunction

    function automatic nuc_t decode_char(input logic [7:0] ch);
        nuc_t n;
        n.bad = 1'b0;
        case (ch)
            8'h41:   n.pair = 2'b00;
            8'h43:   n.pair = 2'b01;
            8'h47:   n.pair = 2'b10;
            8'h54:   n.pair = 2'b11;
            default: begin
                n.pair = 2'b00;
                n.bad  = 1'b1;
            end
        endcase
        return n;
    endfunction

    function automatic logic [1:0] ham2(input pair_t a, input pair_t b);
        pair_t x;
        x = a ^ b;
        return {1'b0, x[1]} + {1'b0, x[0]};
    endfunction

endpackage

// File: rtl/nvd_nuc_map.sv
module nvd_nuc_map
    import nvd_pkg::*;
(
    input  logic [7:0] ch,
    output nuc_t       nuc
);
    always_comb nuc = decode_char(ch);
endmodule

// File: rtl/nvd_bmu.sv
module nvd_bmu
    import nvd_pkg::*;
(
    input  pair_t                      rx,
    output logic [NUM_STATES-1:0][1:0] bm
);
    for (genvar e = 0; e < NUM_STATES; e++) begin : g_bm
        assign bm[e] = ham2(rx, pair_t'(e));
    end
endmodule

// File: rtl/nvd_acs.sv
module nvd_acs #(
    parameter int PM_W = 5
) (
    input  logic [PM_W-1:0] pm_a,
    input  logic [PM_W-1:0] pm_b,
    input  logic [1:0]      bm_a,
    input  logic [1:0]      bm_b,
    output logic [PM_W-1:0] pm_new,
    output logic            pick_b
);
    localparam logic [PM_W:0] SAT = (PM_W+1)'((1 << PM_W) - 1);

    logic [PM_W:0] sum_a, sum_b, sat_a, sat_b;

    always_comb begin
        sum_a  = {1'b0, pm_a} + (PM_W+1)'(bm_a);
        sum_b  = {1'b0, pm_b} + (PM_W+1)'(bm_b);
        sat_a  = (sum_a > SAT) ? SAT : sum_a;
        sat_b  = (sum_b > SAT) ? SAT : sum_b;
        pick_b = sat_b < sat_a;
        pm_new = pick_b ? sat_b[PM_W-1:0] : sat_a[PM_W-1:0];
    end
endmodule

// File: rtl/nvd_best.sv
module nvd_best
    import nvd_pkg::*;
#(
    parameter int PM_W = 5
) (
    input  logic [NUM_STATES-1:0][PM_W-1:0] pm,
    output logic [1:0]                      idx
);
    logic [PM_W-1:0] best;
    always_comb begin
        idx  = 2'd0;
        best = pm[0];
        for (int i = 1; i < NUM_STATES; i++) begin
            if (pm[i] < best) begin
                best = pm[i];
                idx  = 2'(i);
            end
        end
    end
endmodule

// File: rtl/nvd_decoder.sv
module nvd_decoder
    import nvd_pkg::*;
#(
    parameter int BLOCK_LEN = 8,
    parameter int PM_W      = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [7:0]           in_char,
    output logic                 out_valid,
    output logic [BLOCK_LEN-1:0] out_byte,
    output logic                 out_err
);
    localparam int              CNT_W  = $clog2(BLOCK_LEN);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BLOCK_LEN - 1);
    localparam logic [PM_W-1:0] PM_MAX = PM_W'((1 << PM_W) - 1);

    logic [CNT_W-1:0]                       step_q;
    logic [NUM_STATES-1:0][PM_W-1:0]        pm_q, pm_base, pm_d;
    logic [NUM_STATES-1:0][BLOCK_LEN-1:0]   sv_q, sv_base, sv_d;
    logic [NUM_STATES-1:0][1:0]             bm;
    logic                                   err_q, err_base;
    logic [1:0]                             best_idx;
    nuc_t                                   nuc;

    nvd_nuc_map u_map (.ch(in_char), .nuc(nuc));
    nvd_bmu     u_bmu (.rx(nuc.pair), .bm(bm));

    // Block start: metrics and survivors come from the initial values.
    always_comb begin
        for (int s = 0; s < NUM_STATES; s++) begin
            if (step_q == '0) begin
                pm_base[s] = (s == 0) ? '0 : PM_MAX;
                sv_base[s] = '0;
            end else begin
                pm_base[s] = pm_q[s];
                sv_base[s] = sv_q[s];
            end
        end
        err_base = (step_q == '0) ? 1'b0 : err_q;
    end

    // State n = {newest bit, older bit}; predecessors {n[0],0} and {n[0],1}.
    for (genvar n = 0; n < NUM_STATES; n++) begin : g_state
        localparam int    PA = (n % 2) * 2;
        localparam int    PB = PA + 1;
        localparam int    U  = n / 2;
        localparam pair_t EA = expected_pair(2'(PA), 1'(U));
        localparam pair_t EB = expected_pair(2'(PB), 1'(U));

        logic                 pick_b;
        logic [BLOCK_LEN-1:0] sv_pick;

        nvd_acs #(.PM_W(PM_W)) u_acs (
            .pm_a  (pm_base[PA]),
            .pm_b  (pm_base[PB]),
            .bm_a  (bm[EA]),
            .bm_b  (bm[EB]),
            .pm_new(pm_d[n]),
            .pick_b(pick_b)
        );

        assign sv_pick = pick_b ? sv_base[PB] : sv_base[PA];
        assign sv_d[n] = {sv_pick[BLOCK_LEN-2:0], 1'(U)};
    end

    nvd_best #(.PM_W(PM_W)) u_best (.pm(pm_d), .idx(best_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= '0;
            pm_q      <= '0;
            sv_q      <= '0;
            err_q     <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                pm_q   <= pm_d;
                sv_q   <= sv_d;
                err_q  <= err_base | nuc.bad;
                step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
                if (step_q == LAST) begin
                    out_valid <= 1'b1;
                    out_byte  <= sv_d[best_idx];
                    out_err   <= err_base | nuc.bad;
                end
            end
        end
    end
endmodule

// File: rtl/nvd_decoder_chk.sv
module nvd_decoder_chk
    import nvd_pkg::*;
#(
    parameter int BLOCK_LEN = 8,
    parameter int PM_W      = 5
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            in_valid,
    input logic [7:0]                      in_char,
    input logic [$clog2(BLOCK_LEN)-1:0]    step_q,
    input logic [NUM_STATES-1:0][PM_W-1:0] pm_q,
    input logic                            out_valid,
    input logic                            out_err
);
    localparam int               CNT_W = $clog2(BLOCK_LEN);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BLOCK_LEN - 1);

    function automatic logic [PM_W:0] min_pm(input logic [NUM_STATES-1:0][PM_W-1:0] v);
        logic [PM_W:0] m;
        m = {1'b0, v[0]};
        for (int i = 1; i < NUM_STATES; i++)
            if ({1'b0, v[i]} < m) m = {1'b0, v[i]};
        return m;
    endfunction

    function automatic logic illegal(input logic [7:0] c);
        return !(c == 8'h41 || c == 8'h43 || c == 8'h47 || c == 8'h54);
    endfunction

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(step_q) && $stable(pm_q));

    a_r3_pulse_on_last: assert property (@(posedge clk) disable iff (rst)
        in_valid && step_q == LAST |=> out_valid);

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && step_q == LAST));

    a_r4_min_metric_range: assert property (@(posedge clk) disable iff (rst)
        in_valid && step_q != '0 |=>
            min_pm(pm_q) >= $past(min_pm(pm_q)) && min_pm(pm_q) <= $past(min_pm(pm_q)) + 2);

    a_r8_err_on_last_bad: assert property (@(posedge clk) disable iff (rst)
        in_valid && step_q == LAST && illegal(in_char) |=> out_err);
endmodule

bind nvd_decoder nvd_decoder_chk #(.BLOCK_LEN(BLOCK_LEN), .PM_W(PM_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_char  (in_char),
    .step_q   (step_q),
    .pm_q     (pm_q),
    .out_valid(out_valid),
    .out_err  (out_err)
);

// File: tb/test_nvd_decoder.sv
module test_nvd_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_char = 8'h41;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    nvd_decoder i_nvd_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .out_valid(out_valid), .out_byte(out_byte), .out_err(out_err)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] encode(input logic [7:0] msg);
        logic [1:0]  s;
        logic [15:0] cw;
        s = 2'b00;
        for (int i = 7; i >= 0; i--) begin
            cw[2*i+1] = msg[i] ^ s[1] ^ s[0];
            cw[2*i]   = msg[i] ^ s[0];
            s = {msg[i], s[1]};
        end
        return cw;
    endfunction

    function automatic logic [7:0] to_char(input logic [1:0] p);
        case (p)
            2'b00: return 8'h41;
            2'b01: return 8'h43;
            2'b10: return 8'h47;
            default: return 8'h54;
        endcase
    endfunction

    function automatic int dist16(input logic [15:0] a, input logic [15:0] b);
        return $countones(a ^ b);
    endfunction

    function automatic int min_dist(input logic [15:0] rx);
        int m;
        m = 99;
        for (int k = 0; k < 256; k++)
            if (dist16(encode(8'(k)), rx) < m) m = dist16(encode(8'(k)), rx);
        return m;
    endfunction

    // Sends one block; bad_pos >= 0 replaces that character by bad_ch.
    task automatic send_block(input logic [15:0] cw, input int bad_pos, input logic [7:0] bad_ch,
                              input int gaps, output logic [7:0] ob, output logic oe);
        for (int i = 0; i < 8; i++) begin
            for (int g = 0; g < gaps; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                if (i > 0) check(out_valid == 1'b0, "R2 idle gap no output", out_valid, 0);
            end
            @(negedge clk);
            if (i > 0) check(out_valid == 1'b0, "R3 no early valid", out_valid, 0);
            in_valid = 1'b1;
            in_char  = (i == bad_pos) ? bad_ch : to_char(cw[15-2*i -: 2]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R3 valid after eighth", out_valid, 1);
        ob = out_byte;
        oe = out_err;
        @(negedge clk);
        check(out_valid == 1'b0, "R3 single pulse", out_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  ob;
        logic        oe;
        logic [15:0] rx;

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
        check(out_byte == 8'h00, "R9 reset byte", out_byte, 0);
        check(out_err == 1'b0, "R9 reset err", out_err, 0);
        rst = 1'b0;

        // R1 R5: the sample message and every message, some with idle gaps (R2).
        send_block(encode(8'h2D), -1, 8'h00, 0, ob, oe);
        check(ob == 8'h2D, "R1 sample message", ob, 8'h2D);
        for (int m = 0; m < 256; m++) begin
            send_block(encode(8'(m)), -1, 8'h00, (m % 3 == 0) ? 2 : 0, ob, oe);
            check(ob == 8'(m), "R5 error-free decode", ob, m);
            check(oe == 1'b0, "R8 clean block no err", oe, 0);
        end

        // R6: random one to three bit errors, result must be maximum likelihood.
        for (int t = 0; t < 300; t++) begin
            logic [7:0] msg;
            msg = 8'($urandom);
            rx  = encode(msg);
            for (int e = 0; e < 1 + (t % 3); e++) rx[$urandom % 16] ^= 1'b1;
            send_block(rx, -1, 8'h00, 0, ob, oe);
            check(dist16(encode(ob), rx) == min_dist(rx), "R6 ML distance",
                  dist16(encode(ob), rx), min_dist(rx));
        end

        // R7 tie rules.
        send_block(16'h0001, -1, 8'h00, 0, ob, oe);
        check(ob == 8'h00, "R7 tie last 01", ob, 0);
        send_block(16'h0002, -1, 8'h00, 1, ob, oe);
        check(ob == 8'h00, "R7 tie last 10", ob, 0);

        // R8 illegal characters decode as 00 and raise the flag.
        send_block(16'h0000, 3, 8'h58, 0, ob, oe);
        check(oe == 1'b1, "R8 err set mid block", oe, 1);
        check(ob == 8'h00, "R8 illegal as 00", ob, 0);
        send_block(16'h0000, 7, 8'h61, 0, ob, oe);
        check(oe == 1'b1, "R8 err set last char", oe, 1);
        check(ob == 8'h00, "R8 lowercase illegal as 00", ob, 0);
        send_block(encode(8'h96), 0, 8'h00, 0, ob, oe);
        rx = encode(8'h96);
        rx[15:14] = 2'b00;
        check(oe == 1'b1, "R8 err on first char", oe, 1);
        check(dist16(encode(ob), rx) == min_dist(rx), "R8 illegal pair read as 00",
              dist16(encode(ob), rx), min_dist(rx));
        send_block(encode(8'h5A), -1, 8'h00, 0, ob, oe);
        check(oe == 1'b0, "R8 err cleared next block", oe, 0);
        check(ob == 8'h5A, "R8 clean after err", ob, 8'h5A);

        // R4: all-T word decodes to the message whose code is nearest it.
        send_block(16'hFFFF, -1, 8'h00, 0, ob, oe);
        check(dist16(encode(ob), 16'hFFFF) == min_dist(16'hFFFF), "R4 metric path choice",
              dist16(encode(ob), 16'hFFFF), min_dist(16'hFFFF));

        // R9: reset in the middle of a block discards the partial block.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_char  = 8'h54;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R9 reset mid block", out_valid, 0);
        send_block(encode(8'hC3), -1, 8'h00, 0, ob, oe);
        check(ob == 8'hC3, "R9 block after reset", ob, 8'hC3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule